// File: doc/BRIEF.md
# Warp Issue and Dual-Datapath Dispatch

This block is the issue stage of a multi-threaded SIMD core built from several processing partitions. Each warp is bound to one partition by a fixed rule. Every cycle, each partition looks at the warps it owns and picks at most one of them whose instruction can start now. It then sends that instruction to one of two 16-lane datapaths.

The two datapaths are not alike. Path A runs only FP32 work. Path B holds both FP32 and INT32 lanes, but it runs only one kind of operation in a given clock. A 32-thread warp instruction takes a 16-lane path for two cycles, so a path that has just accepted work cannot accept more in the next cycle.

The partition chooses a path from the instruction type and from which paths are busy. In this way it can keep up either 32 FP32 lane-operations per clock, or 16 FP32 plus 16 INT32. Instructions that are neither FP32 nor INT32 use the issue slot and leave on their own strobe. Operand fetch, scoreboarding and the arithmetic itself are handled outside this block. The top level holds four partitions.

Top module: `warp_issue_core`

## Requirements
- R1: Warp `w` is handled only by partition `w % NUM_PARTS`, where it is local slot `w / NUM_PARTS`. When partition `p` issues, `warp_id_o[p]` carries the global warp number.
- R2: In any cycle a partition raises at most one of `path_a_o`, `path_b_o` and `misc_o`, and only for a warp whose `ready_i` bit is set. When no warp is eligible it raises none of them.
- R3: The instruction type is `op_i[2w+1:2w]`: 0 is FP32, 1 is INT32, and 2 or 3 is "misc". An FP32 instruction goes to path A when A is free. It goes to path B only when A is busy and B is free.
- R4: An INT32 instruction goes only to path B, with `b_int_o` high. `b_int_o` is never high without `path_b_o`.
- R5: A path that accepts an instruction is busy for the next cycle (OCC_CYCLES=2), and nothing is dispatched to it during that cycle.
- R6: A ready warp whose possible paths are all busy is passed over that cycle, and another eligible warp may issue instead. The passed-over warp issues once its path is free.
- R7: Selection is round-robin over the eligible warps. The search starts at the local slot after the last one that issued.
- R8: A misc instruction raises `misc_o` and uses the issue slot, but it sends nothing to path A or path B and leaves both paths free.
- R9: Reset clears both busy states of every partition and sets each round-robin pointer so that the first search starts at local slot 0.
- R10: When FP32 warps are ready all the time, a partition issues on every cycle and alternates between A and B. When an FP32 warp and an INT32 warp are ready all the time, it alternates FP32 on A with INT32 on B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | NUM_PARTS*WARPS_PER_PART | Per-warp ready flag, indexed by global warp number |
| op_i | input | 2*NUM_PARTS*WARPS_PER_PART | Per-warp next-instruction type, 2 bits per warp |
| path_a_o | output | NUM_PARTS | Per-partition dispatch strobe to path A |
| path_b_o | output | NUM_PARTS | Per-partition dispatch strobe to path B |
| b_int_o | output | NUM_PARTS | Path B dispatch is INT32 (high) or FP32 (low) |
| misc_o | output | NUM_PARTS | Per-partition strobe for a misc instruction |
| warp_id_o | output | NUM_PARTS*$clog2(NUM_PARTS*WARPS_PER_PART) | Global warp number of the issue, per partition |

## Verification
The directed tests go after these corner cases, and each one shows how a wrong design would behave:
- The cycle just after a dispatch. A path-occupancy bug would let a second instruction into a path that is still busy, or would hold an FP32 warp off path B even though B is free.
- An INT32 warp blocked behind a busy path B while an FP32 warp waits in a later slot. An arbiter that does not skip ineligible warps would idle there, and one that drops the blocked warp would never issue it again.
- Round-robin order after reset and after misc issues. A wrong pointer shows up as a repeated warp or an issue out of order.
- The warp-to-partition map. A wrong map shows up as a warp issuing from the wrong partition or with the wrong global number.

// File: rtl/warp_issue_pkg.sv
package warp_issue_pkg;
  localparam logic [1:0] OP_FP32  = 2'd0;
  localparam logic [1:0] OP_INT32 = 2'd1;

  function automatic logic is_misc(input logic [1:0] op);
    return op[1];
  endfunction
endpackage

// File: rtl/path_occ.sv
module path_occ #(
  parameter int OCC_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  output logic busy_o
);
  localparam int CW = $clog2(OCC_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (take_i) cnt_q <= CW'(OCC_CYCLES - 1);
    else if (busy_o) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  int unsigned cand;

  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    cand  = 0;
    for (int k = 1; k <= N; k++) begin
      cand = (int'(last_i) + k) % N;
      if (!vld_o && req_i[cand]) begin
        vld_o = 1'b1;
        idx_o = IW'(cand);
      end
    end
  end
endmodule

// File: rtl/warp_part.sv
module warp_part
  import warp_issue_pkg::*;
#(
  parameter int WPP        = 8,
  parameter int OCC_CYCLES = 2,
  localparam int IW = (WPP > 1) ? $clog2(WPP) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [WPP-1:0]  ready_i,
  input  logic [2*WPP-1:0] op_i,
  output logic            path_a_o,
  output logic            path_b_o,
  output logic            b_int_o,
  output logic            misc_o,
  output logic [IW-1:0]   idx_o
);
  logic [1:0]     busy;
  logic [1:0]     take;
  logic [WPP-1:0] elig;
  logic [IW-1:0]  last_q;
  logic           vld;
  logic [1:0]     sel_op;
  logic           sel_fp, sel_int;

  for (genvar g = 0; g < 2; g++) begin : g_path
    path_occ #(.OCC_CYCLES(OCC_CYCLES)) u_occ (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .take_i(take[g]),
      .busy_o(busy[g])
    );
  end

  for (genvar w = 0; w < WPP; w++) begin : g_elig
    logic [1:0] op_w;
    assign op_w = op_i[2*w +: 2];
    always_comb begin
      if (is_misc(op_w))         elig[w] = ready_i[w];
      else if (op_w == OP_INT32) elig[w] = ready_i[w] & ~busy[1];
      else                       elig[w] = ready_i[w] & ~(busy[0] & busy[1]);
    end
  end

  rr_pick #(.N(WPP)) u_rr (
    .req_i (elig),
    .last_i(last_q),
    .vld_o (vld),
    .idx_o (idx_o)
  );

  assign sel_op  = op_i[2*idx_o +: 2];
  assign sel_fp  = !is_misc(sel_op) && (sel_op == OP_FP32);
  assign sel_int = !is_misc(sel_op) && (sel_op == OP_INT32);

  assign path_a_o = vld & sel_fp & ~busy[0];
  assign path_b_o = vld & ((sel_fp & busy[0]) | sel_int);
  assign b_int_o  = vld & sel_int;
  assign misc_o   = vld & is_misc(sel_op);
  assign take     = {path_b_o, path_a_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  last_q <= IW'(WPP - 1);
    else if (vld) last_q <= idx_o;
  end
endmodule

// File: rtl/warp_issue_core.sv
module warp_issue_core #(
  parameter int NUM_PARTS      = 4,
  parameter int WARPS_PER_PART = 8,
  parameter int OCC_CYCLES     = 2
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [NUM_PARTS*WARPS_PER_PART-1:0]   ready_i,
  input  logic [2*NUM_PARTS*WARPS_PER_PART-1:0] op_i,
  output logic [NUM_PARTS-1:0]                  path_a_o,
  output logic [NUM_PARTS-1:0]                  path_b_o,
  output logic [NUM_PARTS-1:0]                  b_int_o,
  output logic [NUM_PARTS-1:0]                  misc_o,
  output logic [NUM_PARTS*$clog2(NUM_PARTS*WARPS_PER_PART)-1:0] warp_id_o
);
  localparam int NUM_WARPS = NUM_PARTS * WARPS_PER_PART;
  localparam int WID_W     = $clog2(NUM_WARPS);
  localparam int IW        = (WARPS_PER_PART > 1) ? $clog2(WARPS_PER_PART) : 1;

  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
    logic [WARPS_PER_PART-1:0]   rdy_p;
    logic [2*WARPS_PER_PART-1:0] op_p;
    logic [IW-1:0]               idx_p;

    // static map: global warp = local*NUM_PARTS + p
    for (genvar l = 0; l < WARPS_PER_PART; l++) begin : g_map
      assign rdy_p[l]        = ready_i[l*NUM_PARTS + p];
      assign op_p[2*l +: 2]  = op_i[2*(l*NUM_PARTS + p) +: 2];
    end

    warp_part #(.WPP(WARPS_PER_PART), .OCC_CYCLES(OCC_CYCLES)) u_part (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ready_i (rdy_p),
      .op_i    (op_p),
      .path_a_o(path_a_o[p]),
      .path_b_o(path_b_o[p]),
      .b_int_o (b_int_o[p]),
      .misc_o  (misc_o[p]),
      .idx_o   (idx_p)
    );

    assign warp_id_o[p*WID_W +: WID_W] = WID_W'(int'(idx_p) * NUM_PARTS + p);
  end
endmodule

// File: rtl/warp_issue_chk.sv
module warp_issue_chk #(
  parameter int NUM_PARTS      = 4,
  parameter int WARPS_PER_PART = 8,
  parameter int OCC_CYCLES     = 2
) (
  input logic                                  clk_i,
  input logic                                  rst_ni,
  input logic [NUM_PARTS*WARPS_PER_PART-1:0]   ready_i,
  input logic [2*NUM_PARTS*WARPS_PER_PART-1:0] op_i,
  input logic [NUM_PARTS-1:0]                  path_a_o,
  input logic [NUM_PARTS-1:0]                  path_b_o,
  input logic [NUM_PARTS-1:0]                  b_int_o,
  input logic [NUM_PARTS-1:0]                  misc_o,
  input logic [NUM_PARTS*$clog2(NUM_PARTS*WARPS_PER_PART)-1:0] warp_id_o
);
  localparam int WID_W = $clog2(NUM_PARTS * WARPS_PER_PART);

  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_chk
    logic [WID_W-1:0] wid;
    logic             any;
    assign wid = warp_id_o[p*WID_W +: WID_W];
    assign any = path_a_o[p] | path_b_o[p] | misc_o[p];

    AST_ONE_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({path_a_o[p], path_b_o[p], misc_o[p]})); // R2
    AST_ISSUE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any |-> ready_i[wid]); // R2
    AST_PART_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any |-> (int'(wid) % NUM_PARTS == p)); // R1
    AST_A_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      path_a_o[p] |=> !path_a_o[p]); // R5
    AST_B_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      path_b_o[p] |=> !path_b_o[p]); // R5
    AST_INT_ON_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
      b_int_o[p] |-> (path_b_o[p] && op_i[2*wid +: 2] == 2'd1)); // R4
    AST_A_FP_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      path_a_o[p] |-> (op_i[2*wid +: 2] == 2'd0)); // R4
    AST_FP_PREF_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (path_b_o[p] && !b_int_o[p]) |-> $past(path_a_o[p])); // R3
    AST_MISC_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      misc_o[p] |-> op_i[2*wid + 1]); // R8
  end
endmodule

bind warp_issue_core warp_issue_chk #(
  .NUM_PARTS(NUM_PARTS), .WARPS_PER_PART(WARPS_PER_PART), .OCC_CYCLES(OCC_CYCLES)
) u_chk (.*);

// File: tb/warp_issue_core_tb.sv
module warp_issue_core_tb_top;
  localparam int NP = 4;
  localparam int WPP = 8;
  localparam int NW = NP * WPP;
  localparam int WID_W = $clog2(NW);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NW-1:0]   rdy = '0;
  logic [2*NW-1:0] ops = '0;
  logic [NP-1:0]   pa, pb, bi, mi;
  logic [NP*WID_W-1:0] wid;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  warp_issue_core #(.NUM_PARTS(NP), .WARPS_PER_PART(WPP), .OCC_CYCLES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ready_i(rdy), .op_i(ops),
    .path_a_o(pa), .path_b_o(pb), .b_int_o(bi), .misc_o(mi), .warp_id_o(wid)
  );

  task automatic do_reset();
    rst_ni = 1'b0; rdy = '0; ops = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic set_warp(input int w, input logic [1:0] op);
    rdy[w] = 1'b1;
    ops[2*w +: 2] = op;
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  // flags = {path_a, path_b, b_int, misc}
  task automatic chk(input int p, input logic [3:0] ef, input int eid, input string tag);
    logic [3:0] af;
    int aid;
    af  = {pa[p], pb[p], bi[p], mi[p]};
    aid = int'(wid[p*WID_W +: WID_W]);
    n_chk++;
    if (af !== ef || (ef != 0 && aid != eid)) begin
      n_bad++;
      $display("FAIL %s part%0d: flags=%b id=%0d expected flags=%b id=%0d",
               tag, p, af, aid, ef, eid);
    end
  endtask

  task automatic t_reset_idle();
    do_reset(); #1;
    for (int p = 0; p < NP; p++) chk(p, 4'b0000, 0, "R9 R2 idle after reset");
  endtask

  task automatic t_fp_alternate();
    do_reset();
    set_warp(5, 2'd0); #1;
    chk(1, 4'b1000, 5, "R1 R3 fp to A");
    chk(0, 4'b0000, 0, "R1 other part idle");
    chk(2, 4'b0000, 0, "R1 other part idle");
    chk(3, 4'b0000, 0, "R1 other part idle");
    step(); chk(1, 4'b0100, 5, "R3 R10 fp to B when A busy");
    step(); chk(1, 4'b1000, 5, "R10 fp back to A");
  endtask

  task automatic t_int_gap();
    do_reset();
    set_warp(2, 2'd1); #1;
    chk(2, 4'b0110, 2, "R4 int to B");
    step(); chk(2, 4'b0000, 0, "R5 B busy no issue");
    step(); chk(2, 4'b0110, 2, "R4 R5 int after B free");
  endtask

  task automatic t_rr_misc();
    do_reset();
    set_warp(0, 2'd2); set_warp(4, 2'd3); set_warp(8, 2'd2); #1;
    chk(0, 4'b0001, 0, "R7 R8 misc slot0");
    step(); chk(0, 4'b0001, 4, "R7 R8 misc slot1");
    step(); chk(0, 4'b0001, 8, "R7 misc slot2");
    step(); chk(0, 4'b0001, 0, "R7 wrap to slot0");
  endtask

  task automatic t_skip_blocked();
    do_reset();
    set_warp(3, 2'd1); set_warp(7, 2'd1); set_warp(11, 2'd0); #1;
    chk(3, 4'b0110, 3, "R6 int first");
    step(); chk(3, 4'b1000, 11, "R6 skip blocked int");
    step(); chk(3, 4'b0110, 3, "R6 int after B free");
  endtask

  task automatic t_mixed();
    do_reset();
    set_warp(1, 2'd0); set_warp(5, 2'd1); #1;
    chk(1, 4'b1000, 1, "R10 fp on A");
    step(); chk(1, 4'b0110, 5, "R10 int on B");
    step(); chk(1, 4'b1000, 1, "R10 fp on A again");
    step(); chk(1, 4'b0110, 5, "R10 int on B again");
  endtask

  task automatic t_all_parts();
    do_reset();
    for (int w = 0; w < NP; w++) set_warp(w, 2'd0);
    set_warp(31, 2'd0); #1;
    for (int p = 0; p < NP; p++) chk(p, 4'b1000, p, "R1 R9 each part own warp");
  endtask

  initial begin
    t_reset_idle();
    t_fp_alternate();
    t_int_gap();
    t_rr_misc();
    t_skip_blocked();
    t_mixed();
    t_all_parts();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule